// File: doc/BRIEF.md
# Serial host control port

This block is a four-wire serial slave (serial clock, active-low select, data in, data out) through which an external controller reaches a processing engine's RAM and two local configuration words. Each command is two 16-bit words sent most significant bit first: an address word, then a data word. The top bit of the address word picks the direction, and the remaining fifteen bits are the address.

Addresses below 0x1400 belong to the engine. They are not served locally. The port raises a request to the engine, holding the address, the direction and, for writes, the data word. The engine answers with a one-cycle acknowledge. A write request goes out only after the whole data word has arrived. A read request goes out as soon as the address word is complete, and the word returned with the acknowledge is shifted out during the data word. The host must therefore leave a gap in the serial clock between the two words of an engine read. Addresses 0x1FFE and 0x1FFC hold the card address and the transmit/receive bit offset, and are read and written directly.

The serial pins are sampled with the fast system clock. The serial clock must stay below 4.096 MHz and well under a quarter of the system clock rate.

Top module: `serial_ctrl_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `sdo`, `eng_req`, `overrun`, `card_addr` and `bit_offset` all at zero.
- R2: A command whose address word has bit 15 clear writes the data word to the configuration words: address 0x1FFE stores the low CARD_W bits into `card_addr`, and address 0x1FFC stores the low OFS_W bits into `bit_offset`.
- R3: A command whose address word has bit 15 set, with address 0x1FFE or 0x1FFC, returns the zero-extended stored value on `sdo` during the data word, MSB first. Each bit is valid before the serial clock rises for it.
- R4: For an engine write, `eng_req` stays low until the 16th data bit has been sampled. It then rises with `eng_rd`=0, `eng_addr` equal to the address and `eng_wdata` equal to the data word.
- R5: For an engine read, `eng_req` rises with `eng_rd`=1 after the 16th address bit. The `eng_rdata` value present with `eng_ack` is the word shifted out on `sdo` during the following data word.
- R6: Once `eng_req` is high, it stays high until a cycle with `eng_ack` high, and `eng_addr`, `eng_rd` and `eng_wdata` do not change while it waits.
- R7: An engine-space address word that completes while `eng_req` is high is ignored: no new request is made, its data word is discarded, and `overrun` goes high and stays high until reset.
- R8: Raising `cs_n` discards a partly received word. The next bit after `cs_n` falls again is bit 15 of an address word.
- R9: Writes to any address that is neither engine space nor one of the two configuration words change nothing, and reads from such addresses return zero.
- R10: Address 0x13FF is engine space and address 0x1400 is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to sample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Host serial clock, idle low |
| cs_n | input | 1 | Host select, active low |
| sdi | input | 1 | Serial data from the host, sampled on the rising serial edge |
| sdo | output | 1 | Serial data to the host, updated on the falling serial edge |
| eng_req | output | 1 | Engine request, also the busy flag |
| eng_rd | output | 1 | Direction of the pending request, 1 for read |
| eng_addr | output | ADDR_W | Engine address holding register |
| eng_wdata | output | WORD_W | Engine write-data holding register |
| eng_ack | input | 1 | One-cycle completion from the engine |
| eng_rdata | input | WORD_W | Read word from the engine, valid with `eng_ack` |
| card_addr | output | CARD_W | Card address configuration word |
| bit_offset | output | OFS_W | Transmit/receive bit offset configuration word |
| overrun | output | 1 | Sticky flag for an engine address refused while busy |

## Verification
The checker watches the engine handshake on every cycle. It checks that a request is held and its address, direction and write data stay frozen until it is acknowledged, and that every new request targets engine space. It also checks that the overrun flag never falls outside reset, that reset clears the outputs, and that a configuration write never coincides with a new request. Serial framing can only be shown by the bench's scenarios: the MSB-first shifting, the timing of the first read bit, the discarding of a partial word on deselect, the discarding of a refused command's data word, and the 0x13FF/0x1400 boundary all depend on whole command sequences at the pins.

// File: rtl/scp_pkg.sv
// Package: shared types for the serial control port.
// Assumes nothing beyond standard SystemVerilog.
package scp_pkg;
    // Which word of a two-word command the shifter is receiving.
    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } phase_t;
endpackage

// File: rtl/scp_sync.sv
// Module: scp_sync
// Brings WIDTH asynchronous inputs into the clk domain through STAGES flops.
// Assumes each input is stable for several clk periods between changes.
module scp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    input  logic [WIDTH-1:0] rst_val,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // One flop of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= rst_val;
                else if (g == 0) stage_q[g] <= async_in;
                else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/scp_shift.sv
// Module: scp_shift
// Frames the serial stream into WORD_W-bit words that alternate between
// address and data, and drives sdo from a load-able transmit register.
// Assumes synchronized inputs and a serial clock much slower than clk.
module scp_shift
    import scp_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic              sdi_s,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_val,
    output logic              word_done,
    output logic              word_is_data,
    output logic [WORD_W-1:0] word,
    output logic              sdo
);
    localparam int CNT_W = $clog2(WORD_W);

    logic              sck_d;
    logic [CNT_W-1:0]  bcnt;
    phase_t            phase;
    logic [WORD_W-1:0] sreg;
    logic [WORD_W-1:0] tx;
    logic              sdo_q;
    logic              done_q;
    logic              rise;
    logic              fall;

    assign rise = sck_s & ~sck_d;
    assign fall = ~sck_s & sck_d;

    // Bit counting, shifting in, word phase and serial output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d  <= 1'b0;
            bcnt   <= '0;
            phase  <= PH_ADDR;
            sreg   <= '0;
            tx     <= '0;
            sdo_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            sck_d  <= sck_s;
            done_q <= 1'b0;
            if (cs_n_s) begin
                bcnt  <= '0;
                phase <= PH_ADDR;
                sdo_q <= 1'b0;
            end else begin
                if (rise) begin
                    sreg <= {sreg[WORD_W-2:0], sdi_s};
                    if (bcnt == CNT_W'(WORD_W-1)) begin
                        bcnt   <= '0;
                        done_q <= 1'b1;
                        phase  <= (phase == PH_ADDR) ? PH_DATA : PH_ADDR;
                        if (phase == PH_DATA) sdo_q <= 1'b0;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                if (fall && phase == PH_DATA && bcnt != '0) begin
                    sdo_q <= tx[WORD_W-2];
                    tx    <= {tx[WORD_W-2:0], 1'b0};
                end
                if (load_en) begin
                    tx    <= load_val;
                    sdo_q <= load_val[WORD_W-1];
                end
            end
        end
    end

    assign word_done    = done_q;
    assign word_is_data = (phase == PH_ADDR);
    assign word         = sreg;
    assign sdo          = sdo_q;
endmodule

// File: rtl/scp_ctrl.sv
// Module: scp_ctrl
// Decodes completed words: engine-space requests with holding registers and
// a busy/overrun policy, plus the two local configuration words.
// Assumes word_done pulses once per word with word stable in that cycle.
module scp_ctrl #(
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = 15,
    parameter int CARD_W    = 4,
    parameter int OFS_W     = 9,
    parameter int ENG_LIMIT = 'h1400,
    parameter int CARD_REG  = 'h1FFE,
    parameter int OFS_REG   = 'h1FFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic              word_is_data,
    input  logic [WORD_W-1:0] word,
    input  logic              eng_ack,
    input  logic [WORD_W-1:0] eng_rdata,
    output logic              load_en,
    output logic [WORD_W-1:0] load_val,
    output logic              eng_req,
    output logic              eng_rd,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [WORD_W-1:0] eng_wdata,
    output logic [CARD_W-1:0] card_addr,
    output logic [OFS_W-1:0]  bit_offset,
    output logic              overrun
);
    localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(ENG_LIMIT);
    localparam logic [ADDR_W-1:0] CARD_A  = ADDR_W'(CARD_REG);
    localparam logic [ADDR_W-1:0] OFS_A   = ADDR_W'(OFS_REG);

    logic [ADDR_W-1:0] cmd_addr;
    logic              cmd_rd;
    logic              drop;
    logic [ADDR_W-1:0] w_addr;
    logic              w_rd;
    logic              w_eng;
    logic              addr_done;
    logic              data_done;
    logic [WORD_W-1:0] local_rd;

    assign w_addr    = word[ADDR_W-1:0];
    assign w_rd      = word[WORD_W-1];
    assign w_eng     = (w_addr < LIMIT_A);
    assign addr_done = word_done & ~word_is_data;
    assign data_done = word_done & word_is_data;

    // Read value of a local address; unmapped addresses read as zero.
    always_comb begin
        local_rd = '0;
        if (w_addr == CARD_A)     local_rd = WORD_W'(card_addr);
        else if (w_addr == OFS_A) local_rd = WORD_W'(bit_offset);
    end

    // Transmit load: local reads at address time, engine reads at acknowledge.
    always_comb begin
        load_en  = 1'b0;
        load_val = eng_rdata;
        if (addr_done && w_rd && !w_eng) begin
            load_en  = 1'b1;
            load_val = local_rd;
        end else if (eng_req && eng_ack && eng_rd) begin
            load_en  = 1'b1;
        end
    end

    // Command tracking, engine handshake and configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_addr   <= '0;
            cmd_rd     <= 1'b0;
            drop       <= 1'b0;
            eng_req    <= 1'b0;
            eng_rd     <= 1'b0;
            eng_addr   <= '0;
            eng_wdata  <= '0;
            card_addr  <= '0;
            bit_offset <= '0;
            overrun    <= 1'b0;
        end else begin
            if (eng_req && eng_ack) eng_req <= 1'b0;
            if (addr_done) begin
                cmd_addr <= w_addr;
                cmd_rd   <= w_rd;
                drop     <= w_eng & eng_req;
                if (w_eng && eng_req) begin
                    overrun <= 1'b1;
                end else if (w_eng && w_rd) begin
                    eng_req  <= 1'b1;
                    eng_rd   <= 1'b1;
                    eng_addr <= w_addr;
                end
            end
            if (data_done && !cmd_rd && !drop) begin
                if (cmd_addr < LIMIT_A) begin
                    eng_req   <= 1'b1;
                    eng_rd    <= 1'b0;
                    eng_addr  <= cmd_addr;
                    eng_wdata <= word;
                end else if (cmd_addr == CARD_A) begin
                    card_addr <= word[CARD_W-1:0];
                end else if (cmd_addr == OFS_A) begin
                    bit_offset <= word[OFS_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/serial_ctrl_port.sv
// Module: serial_ctrl_port (top)
// Four-wire serial slave giving a host access to engine RAM through a
// request/acknowledge port and to two local configuration words.
// Assumes the host serial clock is far slower than clk (at least 8x).
module serial_ctrl_port #(
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = WORD_W - 1,
    parameter int CARD_W      = 4,
    parameter int OFS_W       = 9,
    parameter int SYNC_STAGES = 2,
    parameter int ENG_LIMIT   = 'h1400,
    parameter int CARD_REG    = 'h1FFE,
    parameter int OFS_REG     = 'h1FFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              sdi,
    output logic              sdo,
    output logic              eng_req,
    output logic              eng_rd,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [WORD_W-1:0] eng_wdata,
    input  logic              eng_ack,
    input  logic [WORD_W-1:0] eng_rdata,
    output logic [CARD_W-1:0] card_addr,
    output logic [OFS_W-1:0]  bit_offset,
    output logic              overrun
);
    logic [2:0]        pins_s;
    logic              load_en;
    logic [WORD_W-1:0] load_val;
    logic              word_done;
    logic              word_is_data;
    logic [WORD_W-1:0] word;

    scp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sck, cs_n, sdi}),
        .rst_val  (3'b010),
        .sync_out (pins_s)
    );

    scp_shift #(.WORD_W(WORD_W)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .sck_s        (pins_s[2]),
        .cs_n_s       (pins_s[1]),
        .sdi_s        (pins_s[0]),
        .load_en      (load_en),
        .load_val     (load_val),
        .word_done    (word_done),
        .word_is_data (word_is_data),
        .word         (word),
        .sdo          (sdo)
    );

    scp_ctrl #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CARD_W(CARD_W), .OFS_W(OFS_W),
        .ENG_LIMIT(ENG_LIMIT), .CARD_REG(CARD_REG), .OFS_REG(OFS_REG)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_done    (word_done),
        .word_is_data (word_is_data),
        .word         (word),
        .eng_ack      (eng_ack),
        .eng_rdata    (eng_rdata),
        .load_en      (load_en),
        .load_val     (load_val),
        .eng_req      (eng_req),
        .eng_rd       (eng_rd),
        .eng_addr     (eng_addr),
        .eng_wdata    (eng_wdata),
        .card_addr    (card_addr),
        .bit_offset   (bit_offset),
        .overrun      (overrun)
    );
endmodule

// File: rtl/serial_ctrl_port_chk.sv
// Module: serial_ctrl_port_chk
// Cycle-by-cycle properties of the engine handshake and sticky flags,
// bound to every serial_ctrl_port instance.
module serial_ctrl_port_chk #(
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = 15,
    parameter int CARD_W    = 4,
    parameter int OFS_W     = 9,
    parameter int ENG_LIMIT = 'h1400
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eng_req,
    input logic              eng_ack,
    input logic              eng_rd,
    input logic [ADDR_W-1:0] eng_addr,
    input logic [WORD_W-1:0] eng_wdata,
    input logic [CARD_W-1:0] card_addr,
    input logic [OFS_W-1:0]  bit_offset,
    input logic              overrun
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!eng_req && !overrun && card_addr == '0 && bit_offset == '0));

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && !eng_ack |=> eng_req);

    assert_req_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && !eng_ack |=> ($stable(eng_addr) && $stable(eng_rd) && $stable(eng_wdata)));

    assert_req_space_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_req) |-> (eng_addr < ADDR_W'(ENG_LIMIT)));

    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    assert_cfg_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(card_addr) || !$stable(bit_offset)) |-> !$rose(eng_req));
endmodule

bind serial_ctrl_port serial_ctrl_port_chk #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CARD_W(CARD_W), .OFS_W(OFS_W),
    .ENG_LIMIT(ENG_LIMIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eng_req    (eng_req),
    .eng_ack    (eng_ack),
    .eng_rd     (eng_rd),
    .eng_addr   (eng_addr),
    .eng_wdata  (eng_wdata),
    .card_addr  (card_addr),
    .bit_offset (bit_offset),
    .overrun    (overrun)
);

// File: tb/sim_serial_ctrl_port.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_serial_ctrl_port;
    localparam int HALF = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        eng_req;
    logic        eng_rd;
    logic [14:0] eng_addr;
    logic [15:0] eng_wdata;
    logic        eng_ack = 1'b0;
    logic [15:0] eng_rdata;
    logic [3:0]  card_addr;
    logic [8:0]  bit_offset;
    logic        overrun;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // engine model state
    bit          auto_ack = 1;
    int          dcnt = 0;
    int          n_acks = 0;
    logic [14:0] log_addr = '0;
    logic [15:0] log_wdata = '0;
    logic        log_rd = 1'b0;

    always #2 clk = ~clk;

    serial_ctrl_port u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
        .eng_req(eng_req), .eng_rd(eng_rd), .eng_addr(eng_addr),
        .eng_wdata(eng_wdata), .eng_ack(eng_ack), .eng_rdata(eng_rdata),
        .card_addr(card_addr), .bit_offset(bit_offset), .overrun(overrun)
    );

    assign eng_rdata = {1'b0, eng_addr} ^ 16'h5A3C;

    // Engine model: acknowledges a pending request after six cycles.
    always @(posedge clk) begin
        eng_ack <= 1'b0;
        if (rst_n && eng_req && !eng_ack && auto_ack) begin
            if (dcnt == 6) begin
                eng_ack   <= 1'b1;
                dcnt      <= 0;
                n_acks    <= n_acks + 1;
                log_addr  <= eng_addr;
                log_wdata <= eng_wdata;
                log_rd    <= eng_rd;
            end else begin
                dcnt <= dcnt + 1;
            end
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic xfer(input logic [15:0] tx, output logic [15:0] rx);
        for (int i = 15; i >= 0; i--) begin
            sdi = tx[i];
            #HALF;
            rx[i] = sdo;
            sck = 1'b1;
            #HALF;
            sck = 1'b0;
        end
    endtask

    task automatic cmd(input logic [15:0] aw, input logic [15:0] dw, input int gap,
                       output logic [15:0] rx);
        logic [15:0] dummy;
        cs_n = 1'b0;
        #HALF;
        xfer(aw, dummy);
        cycles(gap);
        xfer(dw, rx);
        #HALF;
        cs_n = 1'b1;
        cycles(8);
    endtask

    task automatic t_reset();
        chk("R1 sdo", sdo, 0);
        chk("R1 eng_req", eng_req, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 card_addr", card_addr, 0);
        chk("R1 bit_offset", bit_offset, 0);
    endtask

    task automatic t_cfg_write();
        logic [15:0] rx;
        cmd(16'h1FFE, 16'hFFF6, 4, rx);
        chk("R2 card_addr", card_addr, 4'h6);
        cmd(16'h1FFC, 16'hFF35, 4, rx);
        chk("R2 bit_offset", bit_offset, 9'h135);
        chk("R2 card_addr kept", card_addr, 4'h6);
    endtask

    task automatic t_cfg_read();
        logic [15:0] rx;
        cmd(16'h9FFE, 16'hFFFF, 4, rx);
        chk("R3 read card_addr", rx, 16'h0006);
        cmd(16'h9FFC, 16'h0000, 4, rx);
        chk("R3 read bit_offset", rx, 16'h0135);
    endtask

    task automatic t_unmapped();
        logic [15:0] rx;
        int n0 = n_acks;
        cmd(16'h1500, 16'hFFFF, 4, rx);
        chk("R9 card unchanged", card_addr, 4'h6);
        chk("R9 offset unchanged", bit_offset, 9'h135);
        cmd(16'h9500, 16'h0000, 4, rx);
        chk("R9 read zero", rx, 16'h0000);
        cmd(16'h1400, 16'h1234, 4, rx);
        cycles(20);
        chk("R10 0x1400 no request", n_acks - n0, 0);
        chk("R10 0x1400 req low", eng_req, 0);
    endtask

    task automatic t_eng_write();
        logic [15:0] rx;
        int n0 = n_acks;
        cs_n = 1'b0;
        #HALF;
        xfer(16'h0123, rx);
        cycles(30);
        chk("R4 no req before data", eng_req, 0);
        xfer(16'hBEEF, rx);
        #HALF;
        cs_n = 1'b1;
        cycles(20);
        chk("R4 one request", n_acks - n0, 1);
        chk("R4 addr", log_addr, 15'h0123);
        chk("R4 data", log_wdata, 16'hBEEF);
        chk("R4 dir", log_rd, 0);
        cmd(16'h13FF, 16'h0BAD, 4, rx);
        cycles(20);
        chk("R10 0x13FF engine addr", log_addr, 15'h13FF);
        chk("R10 0x13FF engine data", log_wdata, 16'h0BAD);
    endtask

    task automatic t_eng_read();
        logic [15:0] rx;
        int n0 = n_acks;
        cmd(16'h8042, 16'h0000, 40, rx);
        chk("R5 one request", n_acks - n0, 1);
        chk("R5 dir", log_rd, 1);
        chk("R5 read data", rx, 16'h0042 ^ 16'h5A3C);
        cmd(16'h8FFF, 16'h0000, 40, rx);
        chk("R5 read data 2", rx, 16'h0FFF ^ 16'h5A3C);
    endtask

    task automatic t_cs_abort();
        logic [15:0] rx;
        cs_n = 1'b0;
        #HALF;
        for (int i = 0; i < 5; i++) begin
            sdi = 1'b1;
            #HALF;
            sck = 1'b1;
            #HALF;
            sck = 1'b0;
        end
        #HALF;
        cs_n = 1'b1;
        cycles(10);
        cmd(16'h1FFC, 16'h0077, 4, rx);
        chk("R8 reframed write", bit_offset, 9'h077);
        chk("R8 card unchanged", card_addr, 4'h6);
    endtask

    task automatic t_busy_overrun();
        logic [15:0] rx;
        int n0;
        auto_ack = 0;
        n0 = n_acks;
        cmd(16'h0010, 16'h1111, 4, rx);
        chk("R6 req raised", eng_req, 1);
        cycles(100);
        chk("R6 req held", eng_req, 1);
        chk("R6 addr held", eng_addr, 15'h0010);
        chk("R7 no overrun yet", overrun, 0);
        cmd(16'h8020, 16'h0000, 20, rx);
        chk("R7 overrun set", overrun, 1);
        chk("R7 addr kept", eng_addr, 15'h0010);
        chk("R7 dir kept", eng_rd, 0);
        cmd(16'h0030, 16'h2222, 4, rx);
        chk("R7 wdata kept", eng_wdata, 16'h1111);
        chk("R7 addr kept 2", eng_addr, 15'h0010);
        auto_ack = 1;
        cycles(20);
        chk("R6 released", eng_req, 0);
        chk("R7 single ack", n_acks - n0, 1);
        chk("R7 acked write", log_wdata, 16'h1111);
        chk("R7 overrun sticky", overrun, 1);
        cmd(16'h0031, 16'h3333, 4, rx);
        cycles(20);
        chk("R7 later write served", log_wdata, 16'h3333);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        cycles(5);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_cfg_write();
        t_cfg_read();
        t_unmapped();
        t_eng_write();
        t_eng_read();
        t_cs_abort();
        t_busy_overrun();
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog run did not complete");
            summary();
            $finish;
        end
    end
endmodule